// File: doc/BRIEF.md
# Serial Flash Read Command Engine

This block is the target-side sequencer of a serial flash that serves array reads on a four-wire select/clock/data-in/data-out bus. It runs on the chip's own clock. The bus pins are assumed to be already synchronous to that clock, and each serial clock level is assumed to last at least four system clock cycles. A read transaction proceeds in four steps. The engine first shifts in an 8-bit command and then a 24-bit start address. It then lets any dummy clocks pass that the command requires. Finally it streams bytes from a byte-wide memory read port, stepping the address by one for every byte until the host releases the select line.

Four read commands are recognised, and they differ in two ways: the number of dummy clocks between the address and the first data bit, and whether data leaves on one pin or on two. In the two-pin form, the data-in pin is turned around and carries every second bit of each byte. Any other command leaves the engine silent until the next select. Releasing the select line ends a read at any bit, whole byte or not, and turns both output drivers off.

Top module: `sflash_read_engine`

## Requirements
- R1: While `rst_n` is low, and while `sel_n` is high whatever `sclk` and `sdi` do, `sdo_en` and `sdi_out_en` stay 0 and no memory read is issued.
- R2: Command 03h: 8 command bits and then 24 address bits are sampled on rising `sclk` edges, most significant bit first. The first data bit appears on `sdo` at the falling edge that follows the last address bit. Data bytes leave most significant bit first.
- R3: Command 0Bh inserts 8 dummy clocks after the address before the first data bit. The levels on `sdi` during those clocks are ignored.
- R4: Command 1Bh inserts 16 dummy clocks after the address before the first data bit.
- R5: Command 3Bh inserts 8 dummy clocks and then moves two bits per clock: bits 7, 5, 3, 1 of each byte on `sdo` and bits 6, 4, 2, 0 on `sdi_out`. `sdi_out_en` is 1 only in the data phase of this command.
- R6: `mem_rd_en` pulses for one cycle with `mem_addr` equal to the low `MEM_AW` bits of the start address once the address is complete. It pulses again each time a new byte starts to shift out, each time with the previous address plus one. `mem_rdata` is taken as valid from the cycle after the pulse and held until the next one.
- R7: Address bits above `MEM_AW` are ignored. After the highest address (all `MEM_AW` bits set) the stream continues at address 0.
- R8: Raising `sel_n` at any bit position ends the transaction, with both enables at 0 within two clock cycles. The next transaction starts from the command phase.
- R9: Mode 0 (`sclk` idle low) and mode 3 (`sclk` idle high at select) give identical data.
- R10: An unrecognised command keeps both enables at 0 and issues no memory read until `sel_n` rises.
- R11: While driven, `sdo` and `sdi_out` change only after falling `sclk` edges and never after rising ones.
- R12: Both output enables stay 0 through the command, address and dummy clocks, and become 1 from the first data bit on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_n | input | 1 | Bus select, active low |
| sclk | input | 1 | Bus serial clock |
| sdi | input | 1 | Bus data in (command, address, dummy) |
| sdo | output | 1 | Bus data out |
| sdo_en | output | 1 | Drive enable for `sdo` (0 = high impedance) |
| sdi_out | output | 1 | Second data bit driven back on the data-in pin in two-pin reads |
| sdi_out_en | output | 1 | Drive enable for the data-in pin |
| mem_rd_en | output | 1 | One-cycle memory read strobe |
| mem_addr | output | MEM_AW | Memory byte address |
| mem_rdata | input | 8 | Memory read data, valid the cycle after the strobe |

## Verification
The bench sweeps every read command in both clock modes over start addresses that include the top of the memory with extra high address bits set. This catches a wrong dummy count, which would shift every byte by whole bytes, and a missing wrap, which would return data from beyond the array. It counts memory strobes per transaction and watches the output across rising edges. A design that failed to prefetch, or that fetched twice, would show a wrong strobe count, and one that shifted on the wrong edge would move `sdo` while the host samples. Aborts mid-byte and an unknown command are followed by a normal read, so an engine that keeps stale phase state, or that drives the bus after a bad command, is caught.

// File: rtl/sfr_pkg.sv
// Shared constants, phase type and command decode for the serial flash read
// engine. Assumes a byte-wide data path and at most two dummy bytes.
package sfr_pkg;

    localparam int BYTE_W          = 8;
    localparam int MAX_DUMMY_BYTES = 2;
    localparam int DUMMY_CW        = $clog2(MAX_DUMMY_BYTES + 1);

    localparam logic [BYTE_W-1:0] CMD_READ_SLOW = 8'h03;
    localparam logic [BYTE_W-1:0] CMD_READ_FAST = 8'h0B;
    localparam logic [BYTE_W-1:0] CMD_READ_WIDE = 8'h1B;
    localparam logic [BYTE_W-1:0] CMD_READ_DUAL = 8'h3B;

    typedef enum logic [2:0] {
        PH_CMD,
        PH_ADDR,
        PH_DUMMY,
        PH_DATA,
        PH_SKIP
    } sfr_phase_e;

    typedef struct packed {
        logic                known;
        logic                dual;
        logic [DUMMY_CW-1:0] dummy_bytes;
    } sfr_cmd_t;

    // Map a command byte to its read attributes; unknown bytes give known=0.
    function automatic sfr_cmd_t sfr_decode(input logic [BYTE_W-1:0] op);
        sfr_cmd_t c;
        c = '0;
        case (op)
            CMD_READ_SLOW: begin
                c.known = 1'b1;
            end
            CMD_READ_FAST: begin
                c.known       = 1'b1;
                c.dummy_bytes = DUMMY_CW'(1);
            end
            CMD_READ_WIDE: begin
                c.known       = 1'b1;
                c.dummy_bytes = DUMMY_CW'(2);
            end
            CMD_READ_DUAL: begin
                c.known       = 1'b1;
                c.dual        = 1'b1;
                c.dummy_bytes = DUMMY_CW'(1);
            end
            default: c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/sfr_cmd_seq.sv
// Input-side phase sequencer. Counts rising serial clock edges while the bus
// is selected, shifts in the command and the address (most significant bit
// first), lets the dummy clocks pass and then flags the data phase.
// Assumes: rise is a one-cycle pulse per rising sclk edge; sel low clears all.
module sfr_cmd_seq
    import sfr_pkg::*;
#(
    parameter int ADDR_BITS = 24,
    parameter int MEM_AW    = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              rise,
    input  logic              sdi,
    output logic              in_data,
    output logic              dual,
    output logic              start,
    output logic [MEM_AW-1:0] addr
);

    localparam int DUMMY_BITS_MAX = MAX_DUMMY_BYTES * BYTE_W;
    localparam int CNT_MAX = (ADDR_BITS > DUMMY_BITS_MAX) ? ADDR_BITS : DUMMY_BITS_MAX;
    localparam int CNT_W   = $clog2(CNT_MAX);

    sfr_phase_e        phase;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] cmd_sr;
    sfr_cmd_t          cmd;
    logic [BYTE_W-1:0] cmd_next;
    sfr_cmd_t          dec;
    logic [CNT_W-1:0]  dummy_last;

    // Next command byte, its decode, and the last dummy clock index.
    always_comb begin
        cmd_next   = {cmd_sr[BYTE_W-2:0], sdi};
        dec        = sfr_decode(cmd_next);
        dummy_last = CNT_W'(int'(cmd.dummy_bytes) * BYTE_W - 1);
    end

    // Phase progression on each rising serial clock edge.
    always_ff @(posedge clk) begin
        if (!rst_n || !sel) begin
            phase  <= PH_CMD;
            cnt    <= '0;
            cmd_sr <= '0;
            cmd    <= '0;
            addr   <= '0;
            start  <= 1'b0;
        end else begin
            start <= 1'b0;
            if (rise) begin
                case (phase)
                    PH_CMD: begin
                        cmd_sr <= cmd_next;
                        if (cnt == CNT_W'(BYTE_W - 1)) begin
                            cnt   <= '0;
                            cmd   <= dec;
                            phase <= dec.known ? PH_ADDR : PH_SKIP;
                        end else begin
                            cnt <= cnt + CNT_W'(1);
                        end
                    end
                    PH_ADDR: begin
                        addr <= {addr[MEM_AW-2:0], sdi};
                        if (cnt == CNT_W'(ADDR_BITS - 1)) begin
                            cnt   <= '0;
                            start <= 1'b1;
                            phase <= (cmd.dummy_bytes == '0) ? PH_DATA : PH_DUMMY;
                        end else begin
                            cnt <= cnt + CNT_W'(1);
                        end
                    end
                    PH_DUMMY: begin
                        if (cnt == dummy_last) begin
                            cnt   <= '0;
                            phase <= PH_DATA;
                        end else begin
                            cnt <= cnt + CNT_W'(1);
                        end
                    end
                    default: begin
                        cnt <= cnt;
                    end
                endcase
            end
        end
    end

    assign in_data = (phase == PH_DATA);
    assign dual    = cmd.dual;

endmodule

// File: rtl/sfr_fetch.sv
// Memory fetch pointer. Issues the first read when the address is complete
// and one read per byte-start request after that, each at the next address,
// wrapping naturally at the memory address width.
// Assumes: start and adv never pulse in the same cycle.
module sfr_fetch #(
    parameter int MEM_AW = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              start,
    input  logic [MEM_AW-1:0] start_addr,
    input  logic              adv,
    output logic              rd_en,
    output logic [MEM_AW-1:0] rd_addr
);

    logic [MEM_AW-1:0] ptr;

    // Read strobe and address generation with post-incremented pointer.
    always_ff @(posedge clk) begin
        if (!rst_n || !sel) begin
            rd_en   <= 1'b0;
            rd_addr <= '0;
            ptr     <= '0;
        end else begin
            rd_en <= 1'b0;
            if (start) begin
                rd_en   <= 1'b1;
                rd_addr <= start_addr;
                ptr     <= start_addr + MEM_AW'(1);
            end else if (adv) begin
                rd_en   <= 1'b1;
                rd_addr <= ptr;
                ptr     <= ptr + MEM_AW'(1);
            end
        end
    end

endmodule

// File: rtl/sfr_tx.sv
// Output shifter. On each falling serial clock edge of the data phase it
// either loads the held memory byte (at a byte boundary, asking for the
// next fetch) or shifts by one bit, or by two in the two-pin mode.
// Assumes: fill is stable from the cycle after the preceding fetch strobe.
module sfr_tx
    import sfr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              fall,
    input  logic              in_data,
    input  logic              dual,
    input  logic [BYTE_W-1:0] fill,
    output logic              adv,
    output logic              sdo,
    output logic              sdo_en,
    output logic              sdi_out,
    output logic              sdi_out_en
);

    localparam int POS_W = $clog2(BYTE_W);

    logic [BYTE_W-1:0] obyte;
    logic [POS_W-1:0]  pos;
    logic              drive;

    // Byte load / bit shift on falling edges of the data phase.
    always_ff @(posedge clk) begin
        if (!rst_n || !sel) begin
            obyte <= '0;
            pos   <= '0;
            drive <= 1'b0;
            adv   <= 1'b0;
        end else begin
            adv <= 1'b0;
            if (fall && in_data) begin
                drive <= 1'b1;
                if (pos == '0) begin
                    obyte <= fill;
                    adv   <= 1'b1;
                end else if (dual) begin
                    obyte <= {obyte[BYTE_W-3:0], 2'b00};
                end else begin
                    obyte <= {obyte[BYTE_W-2:0], 1'b0};
                end
                pos <= pos + (dual ? POS_W'(2) : POS_W'(1));
            end
        end
    end

    assign sdo        = obyte[BYTE_W-1];
    assign sdi_out    = obyte[BYTE_W-2];
    assign sdo_en     = drive;
    assign sdi_out_en = drive & dual;

endmodule

// File: rtl/sflash_read_engine.sv
// Top of the serial flash read engine. Detects serial clock edges against
// the system clock and ties together the input sequencer, the fetch pointer
// and the output shifter.
// Assumes: bus pins synchronous to clk, each sclk level held >= 4 clk cycles.
module sflash_read_engine
    import sfr_pkg::*;
#(
    parameter int ADDR_BITS = 24,
    parameter int MEM_AW    = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n,
    input  logic              sclk,
    input  logic              sdi,
    output logic              sdo,
    output logic              sdo_en,
    output logic              sdi_out,
    output logic              sdi_out_en,
    output logic              mem_rd_en,
    output logic [MEM_AW-1:0] mem_addr,
    input  logic [BYTE_W-1:0] mem_rdata
);

    logic              sel;
    logic              sclk_q;
    logic              rise;
    logic              fall;
    logic              in_data;
    logic              dual;
    logic              start;
    logic              adv;
    logic [MEM_AW-1:0] start_addr;

    assign sel = ~sel_n;

    // Previous serial clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
        end else begin
            sclk_q <= sclk;
        end
    end

    assign rise = sel & sclk & ~sclk_q;
    assign fall = sel & ~sclk & sclk_q;

    sfr_cmd_seq #(
        .ADDR_BITS (ADDR_BITS),
        .MEM_AW    (MEM_AW)
    ) i_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel     (sel),
        .rise    (rise),
        .sdi     (sdi),
        .in_data (in_data),
        .dual    (dual),
        .start   (start),
        .addr    (start_addr)
    );

    sfr_fetch #(
        .MEM_AW (MEM_AW)
    ) i_fetch (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel        (sel),
        .start      (start),
        .start_addr (start_addr),
        .adv        (adv),
        .rd_en      (mem_rd_en),
        .rd_addr    (mem_addr)
    );

    sfr_tx i_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel        (sel),
        .fall       (fall),
        .in_data    (in_data),
        .dual       (dual),
        .fill       (mem_rdata),
        .adv        (adv),
        .sdo        (sdo),
        .sdo_en     (sdo_en),
        .sdi_out    (sdi_out),
        .sdi_out_en (sdi_out_en)
    );

endmodule

// File: rtl/sflash_read_engine_chk.sv
// Property checker for the serial flash read engine, bound to the top.
// Tracks the last fetch address per transaction and the cycles since reset.
module sflash_read_engine_chk #(
    parameter int MEM_AW = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sel_n,
    input logic              sclk,
    input logic              sdo,
    input logic              sdo_en,
    input logic              sdi_out_en,
    input logic              mem_rd_en,
    input logic [MEM_AW-1:0] mem_addr
);

    logic [1:0]        age;
    logic              have_prev;
    logic [MEM_AW-1:0] prev_addr;
    logic              settled;

    // Saturating count of cycles since reset, so $past depth 2 is valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            age <= '0;
        end else if (age != 2'd3) begin
            age <= age + 2'd1;
        end
    end

    assign settled = (age == 2'd3);

    // Last fetch address inside the current transaction.
    always_ff @(posedge clk) begin
        if (!rst_n || sel_n) begin
            have_prev <= 1'b0;
            prev_addr <= '0;
        end else if (mem_rd_en) begin
            have_prev <= 1'b1;
            prev_addr <= mem_addr;
        end
    end

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        sel_n |=> !mem_rd_en);

    assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sel_n |=> (!sdo_en && !sdi_out_en));

    assert_pin_pair_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sdi_out_en |-> sdo_en);

    assert_next_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_en && have_prev) |-> (mem_addr == prev_addr + MEM_AW'(1)));

    assert_fall_only_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (settled && sdo_en && $past(sdo_en) && !(!$past(sclk) && $past(sclk, 2)))
        |-> $stable(sdo));

    assert_drive_on_fall_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (settled && $rose(sdo_en)) |-> (!$past(sclk) && $past(sclk, 2)));

endmodule

bind sflash_read_engine sflash_read_engine_chk #(
    .MEM_AW (MEM_AW)
) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel_n      (sel_n),
    .sclk       (sclk),
    .sdo        (sdo),
    .sdo_en     (sdo_en),
    .sdi_out_en (sdi_out_en),
    .mem_rd_en  (mem_rd_en),
    .mem_addr   (mem_addr)
);

// File: tb/test_sflash_read_engine.sv
module test_sflash_read_engine;

    localparam int HALF   = 4;
    localparam int MEM_AW = 20;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              sel_n = 1'b1;
    logic              sclk = 1'b0;
    logic              sdi = 1'b0;
    logic              sdo, sdo_en, sdi_out, sdi_out_en;
    logic              mem_rd_en;
    logic [MEM_AW-1:0] mem_addr;
    logic [7:0]        mem_rdata = 8'h00;

    int  n_chk = 0;
    int  n_fail = 0;
    int  n_rd = 0;
    int  n_ioen = 0;
    bit  done = 1'b0;
    bit  cyc_so, cyc_io, cyc_en, moved_on_rise;

    always #2.5 clk = ~clk;

    sflash_read_engine #(.ADDR_BITS(24), .MEM_AW(MEM_AW)) i_sflash_read_engine (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .sclk(sclk), .sdi(sdi),
        .sdo(sdo), .sdo_en(sdo_en), .sdi_out(sdi_out), .sdi_out_en(sdi_out_en),
        .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata)
    );

    function automatic logic [7:0] pat(input logic [MEM_AW-1:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ {a[19:16], 4'h9};
    endfunction

    // Memory model: data valid the cycle after the strobe, held until next.
    always @(posedge clk) begin
        if (mem_rd_en) begin
            mem_rdata <= pat(mem_addr);
            n_rd      <= n_rd + 1;
        end
        if (sdi_out_en) n_ioen <= n_ioen + 1;
    end

    task automatic check(input bit ok, input string what, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    // One serial clock period: falling half then rising half; sample before rise.
    task bit_cycle(input logic b);
        sclk = 1'b0;
        sdi  = b;
        repeat (HALF) @(negedge clk);
        cyc_so = sdo;
        cyc_io = sdi_out;
        cyc_en = sdo_en;
        sclk = 1'b1;
        repeat (HALF - 1) @(negedge clk);
        if (cyc_en && (sdo !== cyc_so)) moved_on_rise = 1'b1;
        @(negedge clk);
    endtask

    function automatic string cmd_tag(input logic [7:0] op);
        case (op)
            8'h03:   return "R2";
            8'h0B:   return "R3";
            8'h1B:   return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic do_read(input logic [7:0] op, input logic [23:0] addr, input int nbytes,
                           input int partial, input bit m3);
        bit   dual;
        int   dummy;
        int   rd0, io0;
        bit   early;
        int   exp_rd;
        logic [7:0] got, exp;
        string tag;
        dual  = (op == 8'h3B);
        dummy = (op == 8'h0B || op == 8'h3B) ? 8 : ((op == 8'h1B) ? 16 : 0);
        rd0 = n_rd;
        io0 = n_ioen;
        early = 1'b0;
        moved_on_rise = 1'b0;
        @(negedge clk);
        sclk = m3;
        repeat (2) @(negedge clk);
        sel_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int b = 7; b >= 0; b--) begin bit_cycle(op[b]); early |= cyc_en; end
        for (int b = 23; b >= 0; b--) begin bit_cycle(addr[b]); early |= cyc_en; end
        for (int b = 0; b < dummy; b++) begin bit_cycle(b[0]); early |= cyc_en; end
        check(!early, "R12 enable before data", longint'(early), 0);
        for (int k = 0; k < nbytes; k++) begin
            got = '0;
            if (dual) begin
                for (int j = 0; j < 4; j++) begin bit_cycle(1'b0); got = {got[5:0], cyc_so, cyc_io}; end
            end else begin
                for (int j = 0; j < 8; j++) begin bit_cycle(1'b0); got = {got[6:0], cyc_so}; end
            end
            exp = pat(MEM_AW'(addr + 24'(k)));
            tag = cmd_tag(op);
            if (m3) tag = {tag, " R9"};
            if (addr[19:0] + 20'(k) < addr[19:0]) tag = {tag, " R7"};
            check(got == exp, $sformatf("%s byte %0d", tag, k), longint'(got), longint'(exp));
        end
        for (int p = 0; p < partial; p++) bit_cycle(1'b0);
        if (nbytes > 0 || partial > 0)
            check(sdo_en == 1'b1, "R12 driving in data", longint'(sdo_en), 1);
        if (!m3) sclk = 1'b0;
        repeat (HALF) @(negedge clk);
        sel_n = 1'b1;
        repeat (2) @(negedge clk);
        check({sdo_en, sdi_out_en} == 2'b00, "R8 released after select", longint'({sdo_en, sdi_out_en}), 0);
        if (partial == 0 && nbytes > 0) begin
            exp_rd = nbytes + 1 + (m3 ? 0 : 1);
            check(n_rd - rd0 == exp_rd, "R6 fetch count", longint'(n_rd - rd0), longint'(exp_rd));
        end
        if (dual) check(n_ioen > io0, "R5 second pin driven", longint'(n_ioen - io0), 1);
        else      check(n_ioen == io0, "R5 second pin idle", longint'(n_ioen - io0), 0);
        check(!moved_on_rise, "R11 output moved on rising edge", longint'(moved_on_rise), 0);
    endtask

    task automatic do_bad(input logic [7:0] op);
        int rd0;
        bit seen;
        rd0 = n_rd;
        seen = 1'b0;
        @(negedge clk);
        sclk = 1'b0;
        sel_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int b = 7; b >= 0; b--) bit_cycle(op[b]);
        for (int b = 0; b < 48; b++) begin bit_cycle(b[1]); seen |= cyc_en | sdi_out_en; end
        check(!seen, "R10 enable after bad command", longint'(seen), 0);
        check(n_rd == rd0, "R10 reads after bad command", longint'(n_rd - rd0), 0);
        sclk = 1'b0;
        repeat (HALF) @(negedge clk);
        sel_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0]  ops [4];
        logic [23:0] addrs [3];
        int rd0;
        ops[0] = 8'h03; ops[1] = 8'h0B; ops[2] = 8'h1B; ops[3] = 8'h3B;
        addrs[0] = 24'h000000; addrs[1] = 24'h012345; addrs[2] = 24'hAFFFFE;

        repeat (5) @(negedge clk);
        check({sdo_en, sdi_out_en, mem_rd_en} == 3'b000, "R1 reset state",
              longint'({sdo_en, sdi_out_en, mem_rd_en}), 0);
        rst_n = 1'b1;
        rd0 = n_rd;
        for (int c = 0; c < 40; c++) begin
            sclk = c[0];
            sdi  = c[2];
            repeat (HALF) @(negedge clk);
            if (sdo_en || sdi_out_en) check(1'b0, "R1 enable while deselected", 1, 0);
        end
        sclk = 1'b0;
        check(n_rd == rd0, "R1 reads while deselected", longint'(n_rd - rd0), 0);

        for (int o = 0; o < 4; o++)
            for (int m = 0; m < 2; m++)
                for (int a = 0; a < 3; a++)
                    do_read(ops[o], addrs[a], 3, 0, m[0]);

        do_read(8'h0B, 24'h0000F0, 20, 0, 1'b0);
        do_read(8'h3B, 24'hFFFFFC, 8, 0, 1'b1);
        do_read(8'h03, 24'h000100, 1, 3, 1'b0);
        do_read(8'h03, 24'h000200, 2, 0, 1'b0);
        do_read(8'h3B, 24'h000300, 0, 2, 1'b1);
        do_read(8'h1B, 24'h0FFFFF, 2, 0, 1'b1);
        do_bad(8'h9F);
        do_bad(8'h02);
        do_read(8'h0B, 24'h040000, 2, 0, 1'b0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule